// File: doc/BRIEF.md
# Half-Precision Operand Decoder and Widener

This block accepts one 16-bit half-precision operand per cycle, sorts it into one of six categories, and converts it to an exact IEEE single-precision word. A floating-point datapath places it in front of single-precision arithmetic, so half-precision operands can use the wider hardware without any loss of value.

Three mode inputs apply per operand. The first selects an alternative encoding, in which the all-ones exponent is an ordinary normal exponent. The second replaces subnormal half inputs with signed zero. The third replaces every NaN with one fixed canonical NaN. The result, its category and an invalid-operation flag are registered once. They appear with a valid strobe one cycle after the operand is accepted.

Top module: `hp_widen`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. While `rst_n` is low, `out_valid`, `out_word`, `out_class` and `out_invalid` are all zero.
- R2: An operand with exponent field 1..30 widens to the same sign, exponent field plus 112, and the 10 fraction bits followed by 13 zero bits. For example, 0x4540 (5.25) gives 0x40A80000.
- R3: An operand with zero exponent and zero fraction gives a zero of the same sign (0x00000000 or 0x80000000).
- R4: When flushing is off, a subnormal operand is normalised. The exponent becomes 112 minus the count of leading zeros in the 10-bit fraction, and the fraction is the bits below the leading one, left-aligned. The result is exact: 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000.
- R5: When `flush_en` is high, a subnormal operand gives a zero that keeps the operand's sign. Normal operands are not affected.
- R6: In standard mode, exponent 0x1F with zero fraction gives 0x7F800000 or 0xFF800000, according to the sign.
- R7: In standard mode with `dnan_en` low, exponent 0x1F with a nonzero fraction gives the same sign and exponent 0xFF. Fraction bit 22 is forced to 1, half fraction bits 8..0 move to bits 21..13, and the low bits are zero. `out_invalid` is 1 exactly when half fraction bit 9 was 0, which marks a signalling NaN.
- R8: In standard mode with `dnan_en` high, every NaN operand gives 0x7FC00000. `out_invalid` still marks a signalling input.
- R9: When `alt_fmt` is high, exponent 0x1F is treated as a normal value, giving exponent field 143. For example, 0x7FFF gives 0x47FFE000, which is 131008. Such an operand is never classed as infinity or NaN and never raises `out_invalid`. Results for exponent 0 do not depend on `alt_fmt`.
- R10: `out_class` encodes the category of the unflushed operand: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 signalling NaN, 5 quiet NaN. Values 6 and 7 never appear.
- R11: In a cycle where `in_valid` is low, `out_word`, `out_class` and `out_invalid` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand and mode bits are valid this cycle |
| in_half | input | 16 | Half-precision operand: sign, 5-bit exponent, 10-bit fraction |
| alt_fmt | input | 1 | Treat exponent 0x1F as a normal exponent |
| flush_en | input | 1 | Replace subnormal operands with signed zero |
| dnan_en | input | 1 | Replace every NaN result with 0x7FC00000 |
| out_valid | output | 1 | Registered result valid |
| out_word | output | 32 | Widened single-precision word |
| out_class | output | 3 | Operand category (encoding in R10) |
| out_invalid | output | 1 | Operand was a signalling NaN |

## Verification
Two functions can act on the same operand: quietening a signalling NaN and substituting the default NaN. The bench provokes this by presenting signalling NaNs with a nonzero payload, once with `dnan_en` low and once with it high. It then checks that the word takes the canonical value while `out_invalid` still reports the signalling input. The same collision appears with `alt_fmt` high on an all-ones exponent and both other modes enabled. In that case the normal-number path must win, with no NaN word and no invalid flag.

// File: rtl/hp_widen.sv
module hp_widen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_half,
  input  logic        alt_fmt,
  input  logic        flush_en,
  input  logic        dnan_en,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic [2:0]  out_class,
  output logic        out_invalid
);
  localparam int EW = 5;
  localparam int FW = 10;
  localparam int SFW = 23;
  localparam int PAD = SFW - FW;
  localparam logic [7:0] REBIAS = 8'd112;
  localparam logic [31:0] QNAN_DEF = 32'h7FC0_0000;

  localparam logic [2:0] C_ZERO = 3'd0;
  localparam logic [2:0] C_SUB  = 3'd1;
  localparam logic [2:0] C_NORM = 3'd2;
  localparam logic [2:0] C_INF  = 3'd3;
  localparam logic [2:0] C_SNAN = 3'd4;
  localparam logic [2:0] C_QNAN = 3'd5;

  logic          sgn;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;
  logic          ex_zero, ex_ones, top_reserved;

  assign sgn = in_half[15];
  assign ex  = in_half[14:10];
  assign fr  = in_half[9:0];
  assign ex_zero = (ex == '0);
  assign ex_ones = (ex == '1);
  assign top_reserved = ex_ones && !alt_fmt;

  logic [3:0]    lz;
  logic          seen;
  logic [FW-1:0] sub_fr;
  logic [7:0]    sub_ex;

  always_comb begin
    lz = 4'd0;
    seen = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (!seen) begin
        if (fr[i]) seen = 1'b1;
        else lz = lz + 4'd1;
      end
    end
  end

  assign sub_fr = fr << (lz + 4'd1);
  assign sub_ex = REBIAS - {4'd0, lz};

  logic [31:0] n_word;
  logic [2:0]  n_class;
  logic        n_inv;

  always_comb begin
    n_word  = '0;
    n_class = C_NORM;
    n_inv   = 1'b0;
    if (ex_zero) begin
      if (fr == '0) begin
        n_class = C_ZERO;
        n_word  = {sgn, 31'd0};
      end else begin
        n_class = C_SUB;
        n_word  = flush_en ? {sgn, 31'd0} : {sgn, sub_ex, sub_fr, {PAD{1'b0}}};
      end
    end else if (top_reserved) begin
      if (fr == '0) begin
        n_class = C_INF;
        n_word  = {sgn, 8'hFF, {SFW{1'b0}}};
      end else begin
        n_class = fr[FW-1] ? C_QNAN : C_SNAN;
        n_inv   = !fr[FW-1];
        n_word  = dnan_en ? QNAN_DEF : {sgn, 8'hFF, 1'b1, fr[FW-2:0], {PAD{1'b0}}};
      end
    end else begin
      n_word = {sgn, {3'd0, ex} + REBIAS, fr, {PAD{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_class   <= C_ZERO;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= n_word;
        out_class   <= n_class;
        out_invalid <= n_inv;
      end
    end
  end
endmodule

// File: rtl/hp_widen_checker.sv
module hp_widen_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_half,
  input logic        alt_fmt,
  input logic        flush_en,
  input logic        dnan_en,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic [2:0]  out_class,
  input logic        out_invalid
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(out_class) && $stable(out_invalid)));

  assert_default_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dnan_en && !alt_fmt && in_half[14:10] == 5'h1F && in_half[9:0] != 10'd0)
      |=> (out_word == 32'h7FC0_0000));

  assert_alt_top_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alt_fmt && in_half[14:10] == 5'h1F)
      |=> (out_class == 3'd2 && !out_invalid && out_word[30:23] == 8'd143));

  assert_flush_signed_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flush_en && in_half[14:10] == 5'd0)
      |=> (out_word[30:0] == 31'd0 && out_word[31] == $past(in_half[15])));

  assert_class_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class <= 3'd5));
endmodule

bind hp_widen hp_widen_checker u_hp_widen_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
  .alt_fmt(alt_fmt), .flush_en(flush_en), .dnan_en(dnan_en),
  .out_valid(out_valid), .out_word(out_word), .out_class(out_class),
  .out_invalid(out_invalid)
);

// File: tb/hp_widen_bench.sv
module hp_widen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic        alt_fmt = 1'b0, flush_en = 1'b0, dnan_en = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic [2:0]  out_class;
  logic        out_invalid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_widen u_hp_widen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .alt_fmt(alt_fmt), .flush_en(flush_en), .dnan_en(dnan_en),
    .out_valid(out_valid), .out_word(out_word), .out_class(out_class),
    .out_invalid(out_invalid)
  );

  typedef struct packed {
    logic [15:0] h;
    logic        a, f, d;
    logic [31:0] w;
    logic [2:0]  c;
    logic        inv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 3'd0, 1'b0, 4'd3},  // R3
    '{16'h8000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 3'd0, 1'b0, 4'd3},  // R3
    '{16'h3C00, 1'b0, 1'b0, 1'b0, 32'h3F80_0000, 3'd2, 1'b0, 4'd2},  // R2
    '{16'h4540, 1'b0, 1'b0, 1'b0, 32'h40A8_0000, 3'd2, 1'b0, 4'd2},  // R2
    '{16'hC000, 1'b0, 1'b0, 1'b0, 32'hC000_0000, 3'd2, 1'b0, 4'd2},  // R2
    '{16'h7BFF, 1'b0, 1'b0, 1'b0, 32'h477F_E000, 3'd2, 1'b0, 4'd2},  // R2
    '{16'h0001, 1'b0, 1'b0, 1'b0, 32'h3380_0000, 3'd1, 1'b0, 4'd4},  // R4
    '{16'h03FF, 1'b0, 1'b0, 1'b0, 32'h387F_C000, 3'd1, 1'b0, 4'd4},  // R4
    '{16'h8200, 1'b0, 1'b0, 1'b0, 32'hB800_0000, 3'd1, 1'b0, 4'd4},  // R4
    '{16'h0010, 1'b0, 1'b0, 1'b0, 32'h3580_0000, 3'd1, 1'b0, 4'd4},  // R4
    '{16'h03FF, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 3'd1, 1'b0, 4'd5},  // R5
    '{16'h8001, 1'b0, 1'b1, 1'b0, 32'h8000_0000, 3'd1, 1'b0, 4'd5},  // R5
    '{16'h3C00, 1'b0, 1'b1, 1'b0, 32'h3F80_0000, 3'd2, 1'b0, 4'd5},  // R5
    '{16'h7C00, 1'b0, 1'b0, 1'b0, 32'h7F80_0000, 3'd3, 1'b0, 4'd6},  // R6
    '{16'hFC00, 1'b0, 1'b0, 1'b1, 32'hFF80_0000, 3'd3, 1'b0, 4'd6},  // R6
    '{16'h7E01, 1'b0, 1'b0, 1'b0, 32'h7FC0_2000, 3'd5, 1'b0, 4'd7},  // R7
    '{16'h7C01, 1'b0, 1'b0, 1'b0, 32'h7FC0_2000, 3'd4, 1'b1, 4'd7},  // R7
    '{16'hFD00, 1'b0, 1'b0, 1'b0, 32'hFFE0_0000, 3'd4, 1'b1, 4'd7},  // R7
    '{16'hFD00, 1'b0, 1'b0, 1'b1, 32'h7FC0_0000, 3'd4, 1'b1, 4'd8},  // R8
    '{16'hFFFF, 1'b0, 1'b0, 1'b1, 32'h7FC0_0000, 3'd5, 1'b0, 4'd8},  // R8
    '{16'h7C00, 1'b1, 1'b0, 1'b0, 32'h4780_0000, 3'd2, 1'b0, 4'd9},  // R9
    '{16'h7FFF, 1'b1, 1'b1, 1'b1, 32'h47FF_E000, 3'd2, 1'b0, 4'd9},  // R9
    '{16'hFD00, 1'b1, 1'b0, 1'b1, 32'hC7A0_0000, 3'd2, 1'b0, 4'd9},  // R9
    '{16'h03FF, 1'b1, 1'b0, 1'b0, 32'h387F_C000, 3'd1, 1'b0, 4'd9},  // R9
    '{16'h0000, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 4'd9},  // R9
    '{16'h8001, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 3'd1, 1'b0, 4'd10}  // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_half = v.h; alt_fmt = v.a; flush_en = v.f; dnan_en = v.d; in_valid = 1'b1;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    string t;
    t = $sformatf("R%0d vec%0d word", v.req, idx);
    check(t, out_word, v.w);
    t = $sformatf("R10 vec%0d class", idx);
    check(t, {29'd0, out_class}, {29'd0, v.c});
    t = $sformatf("R7 vec%0d invalid", idx);
    check(t, {31'd0, out_invalid}, {31'd0, v.inv});
    t = $sformatf("R1 vec%0d valid", idx);
    check(t, {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset word", out_word, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(TBL[i], i);
    end

    @(negedge clk);
    drive(TBL[3]);
    @(negedge clk);
    check_vec(TBL[3], 3);
    drive(TBL[16]);
    @(negedge clk);
    check_vec(TBL[16], 16);
    drive(TBL[21]);
    @(negedge clk);
    check_vec(TBL[21], 21);
    in_valid = 1'b0;
    in_half = 16'h7C01; alt_fmt = 1'b0; dnan_en = 1'b0;
    @(negedge clk);
    check("R1 valid drops", {31'd0, out_valid}, 32'd0);
    check("R11 word held", out_word, 32'h47FF_E000);
    check("R11 invalid held", {31'd0, out_invalid}, 32'd0);
    @(negedge clk);
    check("R11 class held", {29'd0, out_class}, 32'd2);

    drive(TBL[5]);
    @(negedge clk);
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset mid-run word", out_word, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule